// File: doc/BRIEF.md
# Bridge Read Prefetch Controller

This block sits on the read path of a bus bridge. It accepts one forwarded read request at a time from the initiator side. It decides whether the read may be fetched speculatively, and issues a single fetch order to the target-side engine. That order carries a Dword count and the byte enables to drive. While the data comes back and is handed to the initiator, the controller counts Dwords in both directions. It tells the fetch engine when to stop, tells the initiator engine when to disconnect with the final Dword, and flags any fetched data that was never consumed and must be dropped.

Reads that may have side effects fetch one Dword with the initiator's own byte enables. Burst-style reads, and plain memory reads into a prefetchable window, fetch as far as the nearest aligned boundary allows. In normal operation that boundary is `PF_BND` bytes. In flow-through operation it is 4 kB (`FT_BND`). The length is also trimmed by a programmed maximum and by the free buffer space. Both data-carrying edges use valid/ready. A request is taken only when `req_valid` and `req_ready` are both high. Once raised, `fetch_valid` holds with unchanged `fetch_cnt` and `fetch_be` until `fetch_ready` is seen high. The target side applies back-pressure only through `fetch_ready`. The per-Dword strobes `fill` and `xfer` are plain pulses.

Top module: `pfc_read_ctl`

## Requirements
- R1: Command codes 4'b0010 and 4'b1010 are always non-prefetchable. So is 4'b0110 when `req_pf_win` is 0, and so is any other code. Such a read orders `fetch_cnt` = 1 with `fetch_be` equal to the request's `req_be`.
- R2: Codes 4'b1100 and 4'b1110 are prefetchable, and so is 4'b0110 when `req_pf_win` is 1. These reads order `fetch_be` = 4'hF.
- R3: A request with `req_single` = 1 orders `fetch_cnt` = 1 with `req_be` forwarded, whatever its command.
- R4: When `flow_thru` is 0, a prefetchable read orders max(1, min(D, `max_cnt`, `free_dw`)) Dwords, where D = (PF_BND − addr mod PF_BND)/4.
- R5: When `flow_thru` is 1 and `pend_cnt` = 1, a prefetchable read orders max(1, min(F, `free_dw`)) Dwords, where F = (FT_BND − addr mod FT_BND)/4. `max_cnt` has no effect in this case.
- R6: When `flow_thru` is 1 and `pend_cnt` ≠ 1, a prefetchable read orders max(1, min(F, `max_cnt`, `free_dw`)) Dwords.
- R7: `req_ready` is high only while no read is in progress. `fetch_valid` rises in the cycle after acceptance and holds with stable `fetch_cnt` and `fetch_be` until `fetch_ready` is high.
- R8: `stop_fetch` goes high in the cycle after the fill count reaches the ordered count, or after `tgt_disc`. A `fill` in the same cycle as `tgt_disc` is counted. Fills after the stop are ignored.
- R9: Once fetching has stopped, `disc_last` is high exactly while one fetched Dword remains undelivered. An `xfer` in that cycle ends the read, and `req_ready` is high in the next cycle.
- R10: `frame_end` ends the read, and `req_ready` is high in the next cycle. In that cycle, `discard` is high if and only if the Dwords fetched exceed the Dwords delivered. Both counts include a same-cycle `fill` and `xfer`.
- R11: A `tgt_disc` before any Dword has arrived stops the fetch without raising `disc_last`, and the read ends one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Read request offered |
| req_ready | output | 1 | Controller idle, request taken |
| req_cmd | input | 4 | Bus command code of the read |
| req_addr | input | AW | Start byte address |
| req_pf_win | input | 1 | Address hits a prefetchable memory window |
| req_be | input | 4 | Initiator byte enables, active high |
| req_single | input | 1 | Initiator asks for one Dword only |
| max_cnt | input | CW | Programmed maximum prefetch in Dwords |
| flow_thru | input | 1 | Flow-through operation established |
| pend_cnt | input | PW | Requests pending in the read buffers |
| free_dw | input | CW | Free buffer space in Dwords |
| fetch_valid | output | 1 | Fetch order valid |
| fetch_ready | input | 1 | Target engine takes the order |
| fetch_cnt | output | CW | Dwords to fetch |
| fetch_be | output | 4 | Byte enables to drive on the target bus |
| fill | input | 1 | One Dword arrived from the target |
| tgt_disc | input | 1 | Target disconnected |
| xfer | input | 1 | One Dword handed to the initiator |
| frame_end | input | 1 | Initiator ended the transaction |
| stop_fetch | output | 1 | Stop fetching from the target |
| disc_last | output | 1 | Disconnect with this transfer |
| discard | output | 1 | Drop undelivered fetched data |

## Verification
The discard decision and the counting of Dwords can fall in one cycle. The initiator's end-of-transaction may arrive together with a Dword arriving from the target, a Dword going to the initiator, both, or neither. The bench raises `frame_end` after a random number of fills and deliveries, with random same-cycle `fill` and `xfer`. It judges `discard` against its own tally of fetched and delivered Dwords. A second collision is a target disconnect arriving with a fill. The bench checks that this Dword still counts, by where `disc_last` appears during delivery.

// File: rtl/pfc_pkg.sv
package pfc_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_ISSUE, ST_RUN} trk_state_e;

  localparam logic [3:0] CMD_IO_RD       = 4'b0010;
  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_CFG_RD      = 4'b1010;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
endpackage

// File: rtl/pfc_classify.sv
module pfc_classify
  import pfc_pkg::*;
(
  input  logic [3:0] cmd,
  input  logic       pf_win,
  input  logic       single,
  output logic       use_pf
);
  logic burst_cmd;

  always_comb begin
    unique case (cmd)
      CMD_MEM_RD_MULT, CMD_MEM_RD_LINE: burst_cmd = 1'b1;
      CMD_MEM_RD:                       burst_cmd = pf_win;
      default:                          burst_cmd = 1'b0;
    endcase
    // a one-Dword request never prefetches, whatever its class
    use_pf = burst_cmd && !single;
  end
endmodule

// File: rtl/pfc_sizer.sv
module pfc_sizer #(
  parameter int AW     = 32,
  parameter int PF_BND = 512,
  parameter int FT_BND = 4096,
  parameter int PW     = 4,
  parameter int CW     = $clog2(FT_BND / 4) + 1
) (
  input  logic [AW-1:0] addr,
  input  logic          use_pf,
  input  logic          flow,
  input  logic [PW-1:0] pend,
  input  logic [CW-1:0] max_cnt,
  input  logic [CW-1:0] free_dw,
  output logic [CW-1:0] cnt
);
  localparam int NRM_DW = PF_BND / 4;
  localparam int FT_DW  = FT_BND / 4;

  logic [AW-1:0] off_n, off_f;
  logic [CW-1:0] dist_n, dist_f, base, lim, cap;
  logic          ft_solo;

  always_comb begin
    off_n   = addr % AW'(PF_BND);
    off_f   = addr % AW'(FT_BND);
    dist_n  = CW'(NRM_DW) - CW'(off_n >> 2);
    dist_f  = CW'(FT_DW) - CW'(off_f >> 2);
    ft_solo = flow && (pend == PW'(1));
    base    = flow ? dist_f : dist_n;
    // one pending request in flow-through: the programmed maximum drops out
    if (ft_solo || base < max_cnt) lim = base;
    else                           lim = max_cnt;
    cap = (free_dw < lim) ? free_dw : lim;
    if (!use_pf)          cnt = CW'(1);
    else if (cap == '0)   cnt = CW'(1);
    else                  cnt = cap;
  end

  initial begin
    assert (PF_BND >= 8 && PF_BND <= FT_BND);
  end
endmodule

// File: rtl/pfc_tracker.sv
module pfc_tracker
  import pfc_pkg::*;
#(
  parameter int CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [CW-1:0] in_cnt,
  input  logic [3:0]    in_be,
  input  logic          fetch_ready,
  input  logic          fill,
  input  logic          tgt_disc,
  input  logic          xfer,
  input  logic          frame_end,
  output logic          idle,
  output logic          fetch_valid,
  output logic [CW-1:0] fetch_cnt,
  output logic [3:0]    fetch_be,
  output logic          stop_fetch,
  output logic          disc_last,
  output logic          discard
);
  trk_state_e    state;
  logic [CW-1:0] plan, got, sent, got_n, sent_n;
  logic [3:0]    be_q;
  logic          stopped, run, fill_acc, xfer_acc, stop_set;

  always_comb begin
    run       = (state == ST_RUN);
    fill_acc  = run && fill && !stopped && (got != plan);
    xfer_acc  = run && xfer && (sent != got);
    got_n     = got + CW'(fill_acc);
    sent_n    = sent + CW'(xfer_acc);
    stop_set  = run && !stopped &&
                ((fill_acc && got_n == plan) || tgt_disc || frame_end);
    idle        = (state == ST_IDLE);
    fetch_valid = (state == ST_ISSUE);
    fetch_cnt   = plan;
    fetch_be    = be_q;
    stop_fetch  = run && stopped;
    disc_last   = run && stopped && ((got - sent) == CW'(1));
    discard     = run && frame_end && (got_n != sent_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      plan    <= '0;
      be_q    <= '0;
      got     <= '0;
      sent    <= '0;
      stopped <= 1'b0;
    end else begin
      unique case (state)
        ST_IDLE: if (start) begin
          plan    <= in_cnt;
          be_q    <= in_be;
          got     <= '0;
          sent    <= '0;
          stopped <= 1'b0;
          state   <= ST_ISSUE;
        end
        ST_ISSUE: if (fetch_ready) state <= ST_RUN;
        default: begin
          got  <= got_n;
          sent <= sent_n;
          if (stop_set) stopped <= 1'b1;
          if (frame_end || (xfer_acc && disc_last) ||
              (stopped && got == sent))
            state <= ST_IDLE;
        end
      endcase
    end
  end

  a_r7_order_held: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid && !fetch_ready |=> fetch_valid && $stable(fetch_cnt) && $stable(fetch_be));
  a_r7_one_at_a_time: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> !fetch_valid && !stop_fetch);
  a_r8_no_overfill: assert property (@(posedge clk) disable iff (!rst_n)
    got <= plan && sent <= got);
  a_r9_last_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
    disc_last |-> stop_fetch);
  a_r9_end_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    disc_last && xfer |=> idle);
  a_r10_discard_ends: assert property (@(posedge clk) disable iff (!rst_n)
    discard |=> idle);
endmodule

// File: rtl/pfc_read_ctl.sv
module pfc_read_ctl
  import pfc_pkg::*;
#(
  parameter int AW     = 32,
  parameter int PF_BND = 512,
  parameter int FT_BND = 4096,
  parameter int PW     = 4,
  parameter int CW     = $clog2(FT_BND / 4) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [3:0]    req_cmd,
  input  logic [AW-1:0] req_addr,
  input  logic          req_pf_win,
  input  logic [3:0]    req_be,
  input  logic          req_single,
  input  logic [CW-1:0] max_cnt,
  input  logic          flow_thru,
  input  logic [PW-1:0] pend_cnt,
  input  logic [CW-1:0] free_dw,
  output logic          fetch_valid,
  input  logic          fetch_ready,
  output logic [CW-1:0] fetch_cnt,
  output logic [3:0]    fetch_be,
  input  logic          fill,
  input  logic          tgt_disc,
  input  logic          xfer,
  input  logic          frame_end,
  output logic          stop_fetch,
  output logic          disc_last,
  output logic          discard
);
  logic          use_pf, start;
  logic [CW-1:0] size;
  logic [3:0]    drive_be;

  pfc_classify u_cls (
    .cmd(req_cmd), .pf_win(req_pf_win), .single(req_single), .use_pf(use_pf)
  );

  pfc_sizer #(.AW(AW), .PF_BND(PF_BND), .FT_BND(FT_BND), .PW(PW), .CW(CW)) u_size (
    .addr(req_addr), .use_pf(use_pf), .flow(flow_thru), .pend(pend_cnt),
    .max_cnt(max_cnt), .free_dw(free_dw), .cnt(size)
  );

  assign start    = req_valid && req_ready;
  assign drive_be = use_pf ? 4'hF : req_be;

  pfc_tracker #(.CW(CW)) u_trk (
    .clk(clk), .rst_n(rst_n), .start(start), .in_cnt(size), .in_be(drive_be),
    .fetch_ready(fetch_ready), .fill(fill), .tgt_disc(tgt_disc), .xfer(xfer),
    .frame_end(frame_end), .idle(req_ready), .fetch_valid(fetch_valid),
    .fetch_cnt(fetch_cnt), .fetch_be(fetch_be), .stop_fetch(stop_fetch),
    .disc_last(disc_last), .discard(discard)
  );

  a_r1_io_single: assert property (@(posedge clk) disable iff (!rst_n)
    start && (req_cmd == CMD_IO_RD || req_cmd == CMD_CFG_RD) |=>
      fetch_valid && fetch_cnt == CW'(1) && fetch_be == $past(req_be));
  a_r2_burst_all_lanes: assert property (@(posedge clk) disable iff (!rst_n)
    start && !req_single && (req_cmd == CMD_MEM_RD_LINE || req_cmd == CMD_MEM_RD_MULT) |=>
      fetch_be == 4'hF);
  a_r3_single_dword: assert property (@(posedge clk) disable iff (!rst_n)
    start && req_single |=> fetch_cnt == CW'(1) && fetch_be == $past(req_be));
  a_r4_nonzero_order: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |-> fetch_cnt != '0);
endmodule

// File: tb/pfc_read_ctl_test.sv
`timescale 1ns/1ps
module pfc_read_ctl_test;
  localparam int CW = 11;
  localparam int PW = 4;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_pf_win = 0, req_single = 0, flow_thru = 0;
  logic [3:0] req_cmd = 0, req_be = 0;
  logic [31:0] req_addr = 0;
  logic [CW-1:0] max_cnt = 0, free_dw = 0;
  logic [PW-1:0] pend_cnt = 0;
  logic fetch_ready = 0, fill = 0, tgt_disc = 0, xfer = 0, frame_end = 0;
  logic req_ready, fetch_valid, stop_fetch, disc_last, discard;
  logic [CW-1:0] fetch_cnt;
  logic [3:0] fetch_be;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  pfc_read_ctl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_cmd(req_cmd), .req_addr(req_addr), .req_pf_win(req_pf_win), .req_be(req_be),
    .req_single(req_single), .max_cnt(max_cnt), .flow_thru(flow_thru),
    .pend_cnt(pend_cnt), .free_dw(free_dw), .fetch_valid(fetch_valid),
    .fetch_ready(fetch_ready), .fetch_cnt(fetch_cnt), .fetch_be(fetch_be),
    .fill(fill), .tgt_disc(tgt_disc), .xfer(xfer), .frame_end(frame_end),
    .stop_fetch(stop_fetch), .disc_last(disc_last), .discard(discard)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #1;
  endtask

  function automatic bit is_pf(logic [3:0] c, bit w, bit s);
    return !s && (c == 4'b1100 || c == 4'b1110 || (c == 4'b0110 && w));
  endfunction

  function automatic int exp_cnt(logic [3:0] c, logic [31:0] a, bit w, bit s,
                                 int mx, bit ft, int pd, int fr);
    int d, lim;
    if (!is_pf(c, w, s)) return 1;
    d = ft ? (1024 - int'(a % 4096) / 4) : (128 - int'(a % 512) / 4);
    lim = (ft && pd == 1) ? d : ((mx < d) ? mx : d);
    if (fr < lim) lim = fr;
    if (lim < 1) lim = 1;
    return lim;
  endfunction

  // mode 0: full delivery; 1: target disconnect with fill k; 2: disconnect before data; 3: initiator ends
  task automatic txn(input logic [3:0] c, input logic [31:0] a, input bit w, input logic [3:0] be,
                     input bit s, input int mx, input bit ft, input int pd, input int fr,
                     input int mode, input int k, input bit hold, input bit sf, input bit sx, input int m);
    int e, fetched, dl;
    logic [3:0] ebe;
    e   = exp_cnt(c, a, w, s, mx, ft, pd, fr);
    ebe = is_pf(c, w, s) ? 4'hF : be;
    req_cmd = c; req_addr = a; req_pf_win = w; req_be = be; req_single = s;
    max_cnt = CW'(mx); flow_thru = ft; pend_cnt = PW'(pd); free_dw = CW'(fr);
    req_valid = 1; #1;
    chk(req_ready == 1, "R7 ready when idle", req_ready, 1);
    tick(); req_valid = 0; #1;
    chk(fetch_valid == 1, "R7 order raised", fetch_valid, 1);
    chk(fetch_cnt == CW'(e), "R1/R2/R3/R4/R5/R6 count", fetch_cnt, e);
    chk(fetch_be == ebe, "R1/R2/R3 byte enables", fetch_be, ebe);
    chk(req_ready == 0, "R7 busy", req_ready, 0);
    if (hold) begin
      tick();
      chk(fetch_valid == 1 && fetch_cnt == CW'(e) && fetch_be == ebe,
          "R7 held under back-pressure", fetch_cnt, e);
    end
    fetch_ready = 1; tick(); fetch_ready = 0;
    if (mode == 2) begin
      tgt_disc = 1; tick(); tgt_disc = 0; #1;
      chk(stop_fetch == 1, "R11 stop on early disconnect", stop_fetch, 1);
      chk(disc_last == 0, "R11 no last-data disconnect", disc_last, 0);
      tick();
      chk(req_ready == 1, "R11 ends", req_ready, 1);
      return;
    end
    if (mode == 3) begin
      for (int i = 0; i < k; i++) begin fill = 1; tick(); fill = 0; end
      for (int j = 0; j < m; j++) begin xfer = 1; tick(); xfer = 0; end
      frame_end = 1; fill = sf && (k < e); xfer = sx && (m < k); #1;
      dl = ((k + int'(fill)) != (m + int'(xfer))) ? 1 : 0;
      chk(discard == dl[0], "R10 discard decision", discard, dl);
      tick(); frame_end = 0; fill = 0; xfer = 0; #1;
      chk(req_ready == 1, "R10 ends on frame end", req_ready, 1);
      return;
    end
    fetched = 0;
    for (int i = 0; i < e; i++) begin
      fill = 1;
      if (mode == 1 && i == k) tgt_disc = 1;
      tick(); fill = 0;
      fetched++;
      if (tgt_disc) begin tgt_disc = 0; break; end
      if (fetched < e) chk(stop_fetch == 0, "R8 still fetching", stop_fetch, 0);
    end
    #1;
    chk(stop_fetch == 1, "R8 stop", stop_fetch, 1);
    if (mode == 1) begin
      fill = 1; tick(); fill = 0;  // late fill must not count
    end
    for (int j = 0; j < fetched; j++) begin
      #1;
      chk(disc_last == (j == fetched - 1), "R9/R8 disconnect position", disc_last,
          (j == fetched - 1) ? 1 : 0);
      xfer = 1; tick(); xfer = 0;
    end
    #1;
    chk(req_ready == 1, "R9 back to idle", req_ready, 1);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    int c_sel, mode, e, k, m;
    logic [3:0] cl [6];
    logic [31:0] a;
    bit ft, w, s;
    int mx, pd, fr;
    void'($urandom(32'd5150));
    cl[0] = 4'b0010; cl[1] = 4'b0110; cl[2] = 4'b1010;
    cl[3] = 4'b1100; cl[4] = 4'b1110; cl[5] = 4'b0111;
    repeat (3) tick();
    #1;
    chk(req_ready == 1 && fetch_valid == 0, "R7 reset state", fetch_valid, 0);
    chk(stop_fetch == 0 && disc_last == 0 && discard == 0, "R8 reset outputs", stop_fetch, 0);
    rst_n = 1; tick();

    // directed corners
    txn(4'b0010, 32'h100, 0, 4'h3, 0, 16, 0, 1, 32, 0, 0, 1, 0, 0, 0);   // R1 io
    txn(4'b1010, 32'h104, 1, 4'h5, 0, 16, 0, 1, 32, 0, 0, 0, 0, 0, 0);   // R1 config
    txn(4'b0110, 32'h0, 0, 4'h8, 0, 16, 0, 1, 32, 0, 0, 0, 0, 0, 0);     // R1 mem no window
    txn(4'b0110, 32'h0, 1, 4'h8, 0, 16, 0, 1, 32, 0, 0, 0, 0, 0, 0);     // R2 mem window
    txn(4'b1110, 32'h40, 0, 4'h1, 1, 16, 0, 1, 32, 0, 0, 0, 0, 0, 0);    // R3 single
    txn(4'b1100, 32'h1F4, 0, 4'h0, 0, 16, 0, 1, 32, 0, 0, 0, 0, 0, 0);   // R4 boundary: 3
    txn(4'b1100, 32'h1FC, 0, 4'h0, 0, 16, 0, 1, 32, 0, 0, 0, 0, 0, 0);   // R4 boundary: 1
    txn(4'b1110, 32'h0, 0, 4'h0, 0, 16, 0, 1, 0, 0, 0, 0, 0, 0, 0);      // R4 free zero floor
    txn(4'b1110, 32'h10, 0, 4'h0, 0, 2, 1, 1, 40, 0, 0, 0, 0, 0, 0);     // R5 max ignored -> 40
    txn(4'b1110, 32'h10, 0, 4'h0, 0, 2, 1, 2, 40, 0, 0, 0, 0, 0, 0);     // R6 max applies -> 2
    txn(4'b1110, 32'hFF8, 0, 4'h0, 0, 50, 1, 1, 60, 0, 0, 0, 0, 0, 0);   // R5 4k boundary -> 2
    txn(4'b1100, 32'h0, 0, 4'h0, 0, 8, 0, 1, 32, 1, 2, 0, 0, 0, 0);      // R8 disconnect with fill
    txn(4'b1100, 32'h0, 0, 4'h0, 0, 8, 0, 1, 32, 2, 0, 0, 0, 0, 0);      // R11
    txn(4'b1110, 32'h0, 0, 4'h0, 0, 8, 1, 1, 32, 3, 4, 0, 1, 1, 2);      // R10 both same cycle
    txn(4'b1110, 32'h0, 0, 4'h0, 0, 8, 1, 1, 32, 3, 3, 0, 0, 1, 2);      // R10 all delivered

    for (int n = 0; n < 300; n++) begin
      c_sel = int'($urandom % 6);
      a = $urandom;
      if ($urandom % 3 == 0) a[8:0] = 9'h1E0 | 9'(($urandom % 8) * 4);
      w  = $urandom % 2;
      s  = ($urandom % 8) == 0;
      ft = ($urandom % 3) == 0;
      pd = int'($urandom % 4);
      mx = ($urandom % 6 == 0) ? 1000 : int'($urandom % 48) + 1;
      fr = int'($urandom % 65);
      mode = int'($urandom % 4);
      e = exp_cnt(cl[c_sel], a, w, s, mx, ft, pd, fr);
      k = int'($urandom % e);
      m = (k == 0) ? 0 : int'($urandom % (k + 1));
      txn(cl[c_sel], a, w, 4'($urandom), s, mx, ft, pd, fr, mode, k,
          $urandom % 2, $urandom % 2, $urandom % 2, m);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule